// File: doc/BRIEF.md
# Shared directory coherence controller

This block tracks coherence state for a small set of lines held in an inclusive second-level cache bank that serves as the directory for a single private first-level cache. The first level sends read requests (shared and exclusive), dirty evictions, unblock notices after it installs granted data, and writeback data after a recall. The controller fetches lines from memory, grants data to the first level, recalls lines when the bank evicts them, and acknowledges evictions.

A granted line stays blocked until the requester unblocks it. Requests and bank evictions aimed at a line in a transient or blocked state are back-pressured until the line settles. Unblock and writeback messages are always taken. An eviction can cross a recall, so the first level can send a writeback that reports the crossing. The controller then marks the line so that the eviction request that arrives later is acknowledged as stale, and ownership does not change. One event is handled per cycle, and every result is registered.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset every line is absent, all output valids are low and `error_o` is low.
- R2: A shared read (type 0) to an absent line raises `mem_req_valid_o` one cycle after acceptance. The memory reply then produces exclusive data (response type 0) one cycle later, and the line waits for an unblock.
- R3: An exclusive read (type 1) to an absent line fetches from memory. The reply produces plain data (response type 1), and the line waits for an unblock.
- R4: Reads (types 0, 1), evictions (type 2) and bank replacements aimed at a line that is fetching, waiting for an unblock or being recalled are held with ready low. Unblock (type 3) and writeback messages (types 4, 5) are always ready unless a memory reply arrives in the same cycle.
- R5: An unblock (type 3) to a waiting line makes the first level the owner. Requests to that line become ready again.
- R6: A bank replacement of an owned line sends an invalidate (response type 2). A writeback (type 4) then makes the line absent, so a later read fetches from memory again.
- R7: An eviction (type 2) of an owned line is acknowledged (response type 3), and the bank then holds the line dirty. A later read is served at once with no memory fetch.
- R8: A bank replacement of a dirty line raises `mem_wb_valid_o` and makes the line absent.
- R9: A writeback that reports a crossing (type 5) makes the line absent and marks it. The next eviction to that line is acknowledged, clears the mark and leaves the state unchanged, so the line stays owned and a replacement still sends an invalidate.
- R10: Any event that does not fit the line's state sets `error_o`. The flag stays set until reset.
- R11: Priority runs memory reply, then first-level message, then bank replacement. At most one event is taken per cycle, and at most one output valid is high.
- R12: A bank replacement of an absent line produces no output and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l1_valid_i | input | 1 | First-level message valid |
| l1_type_i | input | 3 | Message type: 0 shared read, 1 exclusive read, 2 eviction, 3 unblock, 4 writeback, 5 writeback after crossing |
| l1_line_i | input | IDX_W (2) | Line index of the message |
| l1_ready_o | output | 1 | Message accepted this cycle when valid |
| repl_valid_i | input | 1 | Bank replacement request |
| repl_line_i | input | IDX_W (2) | Line to replace |
| repl_ready_o | output | 1 | Replacement accepted this cycle when valid |
| mem_rsp_valid_i | input | 1 | Memory fill data arrives |
| mem_rsp_line_i | input | IDX_W (2) | Line of the fill |
| mem_req_valid_o | output | 1 | Memory fetch request |
| mem_req_line_o | output | IDX_W (2) | Line to fetch |
| mem_wb_valid_o | output | 1 | Dirty writeback to memory |
| mem_wb_line_o | output | IDX_W (2) | Line written back |
| rsp_valid_o | output | 1 | Message to the first level valid |
| rsp_type_o | output | 2 | 0 exclusive data, 1 data, 2 invalidate, 3 eviction acknowledge |
| rsp_line_o | output | IDX_W (2) | Line of the message |
| error_o | output | 1 | Sticky protocol error |

## Verification
Ready signals are combinational, so the bench checks them 1 ns after it drives each cycle's inputs. Every registered output is due exactly one clock after the edge at which its event is taken. The bench therefore compares all outputs at the falling edge that follows each rising edge. Memory replies come from a bench responder with a fixed latency of three cycles after the fetch is taken. This lets the bench make a fill collide with a first-level message on a known cycle.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
  typedef enum logic [2:0] {
    LN_ABSENT     = 3'd0,
    LN_FETCH_S    = 3'd1,
    LN_FETCH_X    = 3'd2,
    LN_GRANT_WAIT = 3'd3,
    LN_OWNED      = 3'd4,
    LN_RECALL     = 3'd5,
    LN_DIRTY      = 3'd6
  } line_st_e;

  localparam logic [2:0] MSG_GETS    = 3'd0;
  localparam logic [2:0] MSG_GETX    = 3'd1;
  localparam logic [2:0] MSG_PUTX    = 3'd2;
  localparam logic [2:0] MSG_UNBLK   = 3'd3;
  localparam logic [2:0] MSG_WB      = 3'd4;
  localparam logic [2:0] MSG_WB_RACE = 3'd5;

  typedef enum logic [1:0] {
    RSP_DATA_EXCL = 2'd0,
    RSP_DATA      = 2'd1,
    RSP_INV       = 2'd2,
    RSP_WB_ACK    = 2'd3
  } rsp_e;

  typedef enum logic [3:0] {
    EV_NONE, EV_MEM, EV_GETS, EV_GETX, EV_PUTX,
    EV_UNBLK, EV_WB, EV_WB_RACE, EV_BAD, EV_REPL
  } ev_e;

  typedef enum logic [1:0] {OUT_NONE, OUT_MEM_REQ, OUT_MEM_WB, OUT_RSP} out_e;

  function automatic logic is_stable(line_st_e s);
    return (s == LN_ABSENT) || (s == LN_OWNED) || (s == LN_DIRTY);
  endfunction
endpackage

// File: rtl/coh_dir_arb.sv
module coh_dir_arb
  import coh_dir_pkg::*;
#(
  parameter int unsigned IDX_W = 2
) (
  input  logic             mem_valid_i,
  input  logic [IDX_W-1:0] mem_line_i,
  input  logic             l1_valid_i,
  input  logic [2:0]       l1_type_i,
  input  logic [IDX_W-1:0] l1_line_i,
  input  logic             l1_stable_i,
  input  logic             repl_valid_i,
  input  logic [IDX_W-1:0] repl_line_i,
  input  logic             repl_stable_i,
  output logic             l1_ready_o,
  output logic             repl_ready_o,
  output ev_e              ev_o,
  output logic [IDX_W-1:0] ev_line_o
);
  logic l1_resp, l1_rdy, l1_take, repl_rdy;

  always_comb begin
    // responses never wait on line state; only a fill can stall them
    l1_resp   = (l1_type_i >= MSG_UNBLK);
    l1_rdy    = !mem_valid_i && (l1_resp || l1_stable_i);
    l1_take   = l1_valid_i && l1_rdy;
    repl_rdy  = !mem_valid_i && !l1_take && repl_stable_i;
    ev_o      = EV_NONE;
    ev_line_o = '0;
    if (mem_valid_i) begin
      ev_o      = EV_MEM;
      ev_line_o = mem_line_i;
    end else if (l1_take) begin
      ev_line_o = l1_line_i;
      case (l1_type_i)
        MSG_GETS:    ev_o = EV_GETS;
        MSG_GETX:    ev_o = EV_GETX;
        MSG_PUTX:    ev_o = EV_PUTX;
        MSG_UNBLK:   ev_o = EV_UNBLK;
        MSG_WB:      ev_o = EV_WB;
        MSG_WB_RACE: ev_o = EV_WB_RACE;
        default:     ev_o = EV_BAD;
      endcase
    end else if (repl_valid_i && repl_rdy) begin
      ev_o      = EV_REPL;
      ev_line_o = repl_line_i;
    end
  end

  assign l1_ready_o   = l1_rdy;
  assign repl_ready_o = repl_rdy;
endmodule

// File: rtl/coh_dir_line_fsm.sv
module coh_dir_line_fsm
  import coh_dir_pkg::*;
(
  input  line_st_e st_i,
  input  logic     stale_i,
  input  ev_e      ev_i,
  output line_st_e st_o,
  output logic     stale_o,
  output out_e     out_o,
  output rsp_e     rsp_o,
  output logic     err_o
);
  always_comb begin
    st_o    = st_i;
    stale_o = stale_i;
    out_o   = OUT_NONE;
    rsp_o   = RSP_DATA_EXCL;
    err_o   = 1'b0;
    case (ev_i)
      EV_NONE: ;
      EV_MEM: begin
        if (st_i == LN_FETCH_S || st_i == LN_FETCH_X) begin
          st_o  = LN_GRANT_WAIT;
          out_o = OUT_RSP;
          rsp_o = (st_i == LN_FETCH_S) ? RSP_DATA_EXCL : RSP_DATA;
        end else err_o = 1'b1;
      end
      EV_GETS, EV_GETX: begin
        if (st_i == LN_ABSENT) begin
          st_o  = (ev_i == EV_GETS) ? LN_FETCH_S : LN_FETCH_X;
          out_o = OUT_MEM_REQ;
        end else if (st_i == LN_DIRTY) begin
          st_o  = LN_GRANT_WAIT;
          out_o = OUT_RSP;
          rsp_o = (ev_i == EV_GETS) ? RSP_DATA_EXCL : RSP_DATA;
        end else err_o = 1'b1;
      end
      EV_PUTX: begin
        if (stale_i && is_stable(st_i)) begin
          // eviction crossed a recall: acknowledge, keep ownership
          stale_o = 1'b0;
          out_o   = OUT_RSP;
          rsp_o   = RSP_WB_ACK;
        end else if (st_i == LN_OWNED) begin
          st_o  = LN_DIRTY;
          out_o = OUT_RSP;
          rsp_o = RSP_WB_ACK;
        end else err_o = 1'b1;
      end
      EV_UNBLK: begin
        if (st_i == LN_GRANT_WAIT) st_o = LN_OWNED;
        else err_o = 1'b1;
      end
      EV_WB, EV_WB_RACE: begin
        if (st_i == LN_RECALL) begin
          st_o    = LN_ABSENT;
          stale_o = (ev_i == EV_WB_RACE);
        end else err_o = 1'b1;
      end
      EV_REPL: begin
        if (st_i == LN_OWNED) begin
          st_o  = LN_RECALL;
          out_o = OUT_RSP;
          rsp_o = RSP_INV;
        end else if (st_i == LN_DIRTY) begin
          st_o  = LN_ABSENT;
          out_o = OUT_MEM_WB;
        end else if (st_i != LN_ABSENT) err_o = 1'b1;
      end
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
  import coh_dir_pkg::*;
#(
  parameter int unsigned NUM_LINES = 4,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             l1_valid_i,
  input  logic [2:0]       l1_type_i,
  input  logic [IDX_W-1:0] l1_line_i,
  output logic             l1_ready_o,
  input  logic             repl_valid_i,
  input  logic [IDX_W-1:0] repl_line_i,
  output logic             repl_ready_o,
  input  logic             mem_rsp_valid_i,
  input  logic [IDX_W-1:0] mem_rsp_line_i,
  output logic             mem_req_valid_o,
  output logic [IDX_W-1:0] mem_req_line_o,
  output logic             mem_wb_valid_o,
  output logic [IDX_W-1:0] mem_wb_line_o,
  output logic             rsp_valid_o,
  output logic [1:0]       rsp_type_o,
  output logic [IDX_W-1:0] rsp_line_o,
  output logic             error_o
);
  line_st_e [NUM_LINES-1:0] st_all;
  logic     [NUM_LINES-1:0] stale_all;
  ev_e                      ev;
  logic     [IDX_W-1:0]     ev_line;
  line_st_e                 nxt_st;
  logic                     nxt_stale, ev_err;
  out_e                     ev_out;
  rsp_e                     ev_rsp;

  coh_dir_arb #(.IDX_W(IDX_W)) u_arb (
    .mem_valid_i   (mem_rsp_valid_i),
    .mem_line_i    (mem_rsp_line_i),
    .l1_valid_i    (l1_valid_i),
    .l1_type_i     (l1_type_i),
    .l1_line_i     (l1_line_i),
    .l1_stable_i   (is_stable(st_all[l1_line_i])),
    .repl_valid_i  (repl_valid_i),
    .repl_line_i   (repl_line_i),
    .repl_stable_i (is_stable(st_all[repl_line_i])),
    .l1_ready_o    (l1_ready_o),
    .repl_ready_o  (repl_ready_o),
    .ev_o          (ev),
    .ev_line_o     (ev_line)
  );

  coh_dir_line_fsm u_fsm (
    .st_i    (st_all[ev_line]),
    .stale_i (stale_all[ev_line]),
    .ev_i    (ev),
    .st_o    (nxt_st),
    .stale_o (nxt_stale),
    .out_o   (ev_out),
    .rsp_o   (ev_rsp),
    .err_o   (ev_err)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    line_st_e st_q;
    logic     stale_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q    <= LN_ABSENT;
        stale_q <= 1'b0;
      end else if (ev != EV_NONE && ev_line == IDX_W'(g)) begin
        st_q    <= nxt_st;
        stale_q <= nxt_stale;
      end
    end
    assign st_all[g]    = st_q;
    assign stale_all[g] = stale_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_req_valid_o <= 1'b0;
      mem_wb_valid_o  <= 1'b0;
      rsp_valid_o     <= 1'b0;
      mem_req_line_o  <= '0;
      mem_wb_line_o   <= '0;
      rsp_line_o      <= '0;
      rsp_type_o      <= '0;
      error_o         <= 1'b0;
    end else begin
      mem_req_valid_o <= (ev != EV_NONE) && (ev_out == OUT_MEM_REQ);
      mem_wb_valid_o  <= (ev != EV_NONE) && (ev_out == OUT_MEM_WB);
      rsp_valid_o     <= (ev != EV_NONE) && (ev_out == OUT_RSP);
      mem_req_line_o  <= ev_line;
      mem_wb_line_o   <= ev_line;
      rsp_line_o      <= ev_line;
      rsp_type_o      <= ev_rsp;
      error_o         <= error_o | ((ev != EV_NONE) && ev_err);
    end
  end
endmodule

// File: rtl/coh_dir_chk.sv
module coh_dir_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       l1_valid_i,
  input logic [2:0] l1_type_i,
  input logic       l1_ready_o,
  input logic       repl_valid_i,
  input logic       repl_ready_o,
  input logic       mem_rsp_valid_i,
  input logic       mem_req_valid_o,
  input logic       mem_wb_valid_o,
  input logic       rsp_valid_o,
  input logic       error_o
);
  logic any_ev;
  assign any_ev = mem_rsp_valid_i || (l1_valid_i && l1_ready_o) ||
                  (repl_valid_i && repl_ready_o);

  a_r10_error_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> error_o);

  a_r11_fill_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rsp_valid_i |-> (!l1_ready_o && !repl_ready_o));

  a_r4_resp_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_rsp_valid_i && l1_type_i >= 3'd3) |-> l1_ready_o);

  a_r11_one_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({mem_rsp_valid_i, l1_valid_i && l1_ready_o,
                repl_valid_i && repl_ready_o}) <= 1);

  a_r11_one_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rsp_valid_o, mem_req_valid_o, mem_wb_valid_o}));

  a_r2_output_needs_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_ev |=> (!rsp_valid_o && !mem_req_valid_o && !mem_wb_valid_o));
endmodule

bind coh_dir_ctrl coh_dir_chk u_chk (.*);

// File: tb/tb_coh_dir_ctrl.sv
`timescale 1ns/1ps
module tb_coh_dir_ctrl;
  localparam int NL  = 4;
  localparam int LAT = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       l1_valid_i = 1'b0;
  logic [2:0] l1_type_i = '0;
  logic [1:0] l1_line_i = '0;
  logic       l1_ready_o;
  logic       repl_valid_i = 1'b0;
  logic [1:0] repl_line_i = '0;
  logic       repl_ready_o;
  logic       mem_rsp_valid_i = 1'b0;
  logic [1:0] mem_rsp_line_i = '0;
  logic       mem_req_valid_o, mem_wb_valid_o, rsp_valid_o, error_o;
  logic [1:0] mem_req_line_o, mem_wb_line_o, rsp_line_o, rsp_type_o;

  always #10 clk_i = ~clk_i;

  coh_dir_ctrl #(.NUM_LINES(NL)) dut (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  // model: 0 absent 1 fetch-shared 2 fetch-excl 3 wait-unblock 4 owned 5 recall 6 dirty
  int mst[NL];
  bit mstale[NL];
  bit merr;
  int mq_line[$], mq_due[$];
  bit e_rv, e_mq, e_wb;
  int e_rt, e_rl, e_ml, e_wl;

  function automatic bit settled(int s);
    return s == 0 || s == 4 || s == 6;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic send(int t, int l);
    e_rv = 1; e_rt = t; e_rl = l;
  endtask

  // e: 0 fill 1 shared read 2 excl read 3 evict 4 unblock 5 wb 6 wb-crossed 7 replace
  task automatic model(int e, int l);
    int s = mst[l];
    case (e)
      0: if (s == 1 || s == 2) begin send(s == 1 ? 0 : 1, l); mst[l] = 3; end else merr = 1;
      1, 2: if (s == 0) begin
              e_mq = 1; e_ml = l; mst[l] = e;
              mq_line.push_back(l); mq_due.push_back(cyc + LAT);
            end else if (s == 6) begin send(e == 1 ? 0 : 1, l); mst[l] = 3; end
            else merr = 1;
      3: if (mstale[l] && settled(s)) begin send(3, l); mstale[l] = 0; end
         else if (s == 4) begin send(3, l); mst[l] = 6; end else merr = 1;
      4: if (s == 3) mst[l] = 4; else merr = 1;
      5, 6: if (s == 5) begin mst[l] = 0; mstale[l] = (e == 6); end else merr = 1;
      7: if (s == 4) begin send(2, l); mst[l] = 5; end
         else if (s == 6) begin e_wb = 1; e_wl = l; mst[l] = 0; end
         else if (s != 0) merr = 1;
      default: merr = 1;
    endcase
  endtask

  task automatic step(bit lv, int lt, int ll, bit rv, int rl, string tag);
    bit mv = 0, xl, xr;
    int ml = 0;
    if (mq_due.size() > 0 && mq_due[0] <= cyc) begin
      mv = 1; ml = mq_line.pop_front(); void'(mq_due.pop_front());
    end
    mem_rsp_valid_i = mv; mem_rsp_line_i = 2'(ml);
    l1_valid_i = lv; l1_type_i = 3'(lt); l1_line_i = 2'(ll);
    repl_valid_i = rv; repl_line_i = 2'(rl);
    #1;
    xl = !mv && (lt >= 3 || settled(mst[ll]));
    xr = !mv && !(lv && xl) && settled(mst[rl]);
    chk(l1_ready_o === xl, tag, "l1_ready", int'(l1_ready_o), int'(xl));
    chk(repl_ready_o === xr, tag, "repl_ready", int'(repl_ready_o), int'(xr));
    e_rv = 0; e_mq = 0; e_wb = 0;
    if (mv) model(0, ml);
    else if (lv && xl) model(lt + 1, ll);
    else if (rv && xr) model(7, rl);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(rsp_valid_o === e_rv, tag, "rsp_valid", int'(rsp_valid_o), int'(e_rv));
    if (e_rv) begin
      chk(int'(rsp_type_o) == e_rt, tag, "rsp_type", int'(rsp_type_o), e_rt);
      chk(int'(rsp_line_o) == e_rl, tag, "rsp_line", int'(rsp_line_o), e_rl);
    end
    chk(mem_req_valid_o === e_mq, tag, "mem_req", int'(mem_req_valid_o), int'(e_mq));
    if (e_mq) chk(int'(mem_req_line_o) == e_ml, tag, "mem_req_line", int'(mem_req_line_o), e_ml);
    chk(mem_wb_valid_o === e_wb, tag, "mem_wb", int'(mem_wb_valid_o), int'(e_wb));
    if (e_wb) chk(int'(mem_wb_line_o) == e_wl, tag, "mem_wb_line", int'(mem_wb_line_o), e_wl);
    chk(error_o === merr, tag, "error", int'(error_o), int'(merr));
    cyc++;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) begin mst[i] = 0; mstale[i] = 0; end
    merr = 0;
    repeat (3) @(negedge clk_i);
    chk(!rsp_valid_o && !mem_req_valid_o && !mem_wb_valid_o, "R1", "valids in reset",
        int'(rsp_valid_o | mem_req_valid_o | mem_wb_valid_o), 0);
    chk(error_o === 1'b0, "R1", "error in reset", int'(error_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    idle(1, "R1");
    // R2 shared read on absent line, blocked meanwhile (R4)
    step(1, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 1, 0, "R4");
    idle(3, "R2");
    step(1, 1, 0, 0, 0, "R4");
    step(1, 3, 0, 0, 0, "R5");
    // R7 eviction then served from dirty
    step(1, 2, 0, 0, 0, "R7");
    step(1, 0, 0, 0, 0, "R7");
    step(1, 3, 0, 0, 0, "R7");
    // R6 recall then refetch
    step(0, 0, 0, 1, 0, "R6");
    step(1, 0, 0, 0, 0, "R4");
    step(1, 4, 0, 0, 0, "R6");
    step(1, 0, 0, 0, 0, "R6");
    idle(3, "R6");
    step(1, 3, 0, 0, 0, "R5");
    // R3 exclusive read
    step(1, 1, 1, 0, 0, "R3");
    idle(3, "R3");
    step(1, 3, 1, 0, 0, "R3");
    // R9 eviction crossing a recall
    step(0, 0, 0, 1, 1, "R9");
    step(1, 5, 1, 0, 0, "R9");
    step(1, 1, 1, 0, 0, "R9");
    step(1, 2, 1, 0, 0, "R9");
    idle(3, "R9");
    step(1, 2, 1, 0, 0, "R9");
    step(1, 3, 1, 0, 0, "R9");
    step(1, 2, 1, 0, 0, "R9");
    step(0, 0, 0, 1, 1, "R9");
    step(1, 4, 1, 0, 0, "R9");
    // R8 dirty replacement
    step(1, 0, 2, 0, 0, "R8");
    idle(3, "R8");
    step(1, 3, 2, 0, 0, "R8");
    step(1, 2, 2, 0, 0, "R8");
    step(0, 0, 0, 1, 2, "R8");
    // R12 replacement of absent line
    step(0, 0, 0, 1, 3, "R12");
    idle(1, "R12");
    // R11 fill collides with a message and a replacement
    step(1, 0, 3, 0, 0, "R11");
    idle(2, "R11");
    step(1, 0, 2, 1, 0, "R11");
    step(1, 0, 2, 0, 0, "R11");
    idle(3, "R11");
    step(1, 3, 3, 0, 0, "R11");
    step(1, 3, 2, 0, 0, "R11");
    // R10 unexpected unblock, sticky error
    step(1, 3, 3, 0, 0, "R10");
    idle(2, "R10");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule